// File: doc/BRIEF.md
# Reduced Four-Class Mealy Sequence Machine

This block is a small synchronous Mealy machine. It takes one serial bit per clock and returns one output bit. Its behaviour matches a fixed eight-state transition and output table. Equivalent states of that table have been merged into four classes, so the block holds only two bits of state. The output is formed combinationally from the present class and the present input bit. A change on the input therefore shows on the output within the same clock period, before the next edge.

A synchronous, active-high reset returns the machine to its home class. The current class code is also driven out so that it can be observed during debugging. The classes, their codes and their behaviour are listed below. The reference table is referred to as starting from its first state, labelled A, whose class is K0.

Top module: `min4_mealy`

## Requirements
- R1: When `rst` is high at a rising clock edge, `st_code` is 2'b00 after that edge. This holds whatever `x_in` is, including a cycle in which `x_in` would otherwise cause a transition.
- R2: `z_out` is a combinational function of the present class and `x_in`. A change on `x_in` between clock edges changes `z_out` at once, with no clock edge in between.
- R3: In class K0 (code 2'b00), `x_in`=0 gives `z_out`=1 and the next class is K0. `x_in`=1 gives `z_out`=0 and the next class is K1.
- R4: In class K1 (code 2'b01), `x_in`=0 gives `z_out`=0 and the next class is K1. `x_in`=1 gives `z_out`=0 and the next class is K3.
- R5: In class K2 (code 2'b10), `x_in`=0 gives `z_out`=1 and the next class is K3. `x_in`=1 gives `z_out`=1 and the next class is K0.
- R6: In class K3 (code 2'b11), `x_in`=0 gives `z_out`=1 and the next class is K1. `x_in`=1 gives `z_out`=0 and the next class is K2.
- R7: `st_code` carries the class code: K0=2'b00, K1=2'b01, K2=2'b10, K3=2'b11. The classes group the eight reference states as follows: K0 = {A,E}, K1 = {B,D,G}, K2 = {C,F}, K3 = {H}.
- R8: For any input stream applied after reset, the sequence on `z_out` equals the sequence produced by the unreduced eight-state table started in state A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; sends the machine to K0 |
| x_in | input | 1 | Serial input bit |
| z_out | output | 1 | Mealy output, from the present class and `x_in` |
| st_code | output | 2 | Present class code, for debugging |

## Verification
Two things can fall in the same clock edge: a synchronous reset and an input-driven transition. The bench provokes this case. It walks the machine into K3 and then raises `rst` while `x_in`=1, a value that would otherwise move the machine to K2. The case is judged by the class code after the edge, which must be K0.

The other overlap lies within a single cycle, where the combinational output and the pending transition share the same input bit. For this the bench toggles `x_in` before each edge. It checks that `z_out` follows both values at once, and then checks the class reached after the edge against an unreduced eight-state reference model.

// File: rtl/min4_mealy_pkg.sv
package min4_mealy_pkg;
  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    K0 = 2'b00,
    K1 = 2'b01,
    K2 = 2'b10,
    K3 = 2'b11
  } cls_t;

  // class transition of the merged table
  function automatic cls_t cls_step(input cls_t c, input logic x);
    cls_t n;
    unique case (c)
      K0: n = x ? K1 : K0;
      K1: n = x ? K3 : K1;
      K2: n = x ? K0 : K3;
      default: n = x ? K2 : K1;
    endcase
    return n;
  endfunction

  // Mealy output of the merged table
  function automatic logic cls_emit(input cls_t c, input logic x);
    logic z;
    unique case (c)
      K0: z = ~x;
      K1: z = 1'b0;
      K2: z = 1'b1;
      default: z = ~x;
    endcase
    return z;
  endfunction
endpackage

// File: rtl/min4_mealy_next.sv
module min4_mealy_next
  import min4_mealy_pkg::*;
(
  input  cls_t cur_i,
  input  logic x_i,
  output cls_t nxt_o
);
  always_comb nxt_o = cls_step(cur_i, x_i);
endmodule

// File: rtl/min4_mealy_out.sv
module min4_mealy_out
  import min4_mealy_pkg::*;
(
  input  cls_t cur_i,
  input  logic x_i,
  output logic z_o
);
  always_comb z_o = cls_emit(cur_i, x_i);
endmodule

// File: rtl/min4_mealy.sv
module min4_mealy
  import min4_mealy_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             x_in,
  output logic             z_out,
  output logic [CLS_W-1:0] st_code
);
  cls_t cur_q;
  cls_t nxt_w;
  logic z_w;

  min4_mealy_next u_next (
    .cur_i (cur_q),
    .x_i   (x_in),
    .nxt_o (nxt_w)
  );

  min4_mealy_out u_out (
    .cur_i (cur_q),
    .x_i   (x_in),
    .z_o   (z_w)
  );

  always_ff @(posedge clk) begin
    if (rst) cur_q <= K0;
    else     cur_q <= nxt_w;
  end

  assign z_out   = z_w;
  assign st_code = cur_q;
endmodule

// File: rtl/min4_mealy_chk.sv
module min4_mealy_chk (
  input logic       clk,
  input logic       rst,
  input logic       x_in,
  input logic       z_out,
  input logic [1:0] st_code
);
  assert_reset_home_R1: assert property (@(posedge clk)
    rst |=> (st_code == 2'b00));

  assert_k0_leave_R3: assert property (@(posedge clk) disable iff (rst)
    (st_code == 2'b00 && x_in) |=> (st_code == 2'b01));

  assert_k1_mute_R4: assert property (@(posedge clk) disable iff (rst)
    (st_code == 2'b01) |-> !z_out);

  assert_k1_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (st_code == 2'b01 && !x_in) |=> (st_code == 2'b01));

  assert_k2_loud_R5: assert property (@(posedge clk) disable iff (rst)
    (st_code == 2'b10) |-> z_out);

  assert_k3_fwd_R6: assert property (@(posedge clk) disable iff (rst)
    (st_code == 2'b11 && x_in) |=> (st_code == 2'b10));
endmodule

bind min4_mealy min4_mealy_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .x_in    (x_in),
  .z_out   (z_out),
  .st_code (st_code)
);

// File: tb/min4_mealy_tb_top.sv
module min4_mealy_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x_in = 1'b0;
  logic z_out;
  logic [1:0] st_code;
  int total = 0;
  int bad = 0;
  int rs = 0; // reference state 0..7 = A..H

  always #5 clk = ~clk;

  min4_mealy dut_i (
    .clk     (clk),
    .rst     (rst),
    .x_in    (x_in),
    .z_out   (z_out),
    .st_code (st_code)
  );

  // unreduced eight-state reference
  function automatic int ref_next(input int s, input bit x);
    case (s)
      0: return x ? 6 : 4;
      1: return x ? 7 : 1;
      2: return x ? 4 : 7;
      3: return x ? 7 : 6;
      4: return x ? 1 : 4;
      5: return x ? 0 : 7;
      6: return x ? 7 : 3;
      default: return x ? 5 : 6;
    endcase
  endfunction

  function automatic int ref_out(input int s, input bit x);
    case (s)
      0, 4, 7: return x ? 0 : 1;
      2, 5:    return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int class_of(input int s);
    case (s)
      0, 4:    return 0;
      1, 3, 6: return 1;
      2, 5:    return 2;
      default: return 3;
    endcase
  endfunction

  function automatic string cls_tag(input int c);
    case (c)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit longrun);
    @(negedge clk);
    x_in = ~v;
    #1;
    chk("R2", "z for opposite x", int'(z_out), ref_out(rs, ~v));
    x_in = v;
    #1;
    chk(longrun ? "R8" : cls_tag(class_of(rs)), "z", int'(z_out), ref_out(rs, v));
    chk("R7", "class code", int'(st_code), class_of(rs));
    @(posedge clk);
    rs = ref_next(rs, v);
  endtask

  task automatic do_reset(input bit v);
    @(negedge clk);
    rst = 1'b1;
    x_in = v;
    @(posedge clk);
    #1;
    chk("R1", "code after reset", int'(st_code), 0);
    rs = 0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog R8 act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "code at reset", int'(st_code), 0);
    @(negedge clk);
    rst = 1'b0;

    // sweep every class with every input; prefixes reach K0,K1,K3,K2
    for (int c = 0; c < 4; c++) begin
      for (int v = 0; v < 2; v++) begin
        do_reset(1'b0);
        for (int p = 0; p < c; p++) step(1'b1, 1'b0);
        step(bit'(v), 1'b0);
        @(negedge clk);
        #1;
        chk(cls_tag(class_of(rs)), "class after step", int'(st_code), class_of(rs));
      end
    end

    // reset edge coinciding with x=1 while in K3 (state H)
    do_reset(1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    chk("R1", "reference reached H", rs, 7);
    do_reset(1'b1);

    // long random streams against the eight-state reference
    for (int r = 0; r < 4; r++) begin
      do_reset(1'b0);
      for (int i = 0; i < 1500; i++) step(bit'($urandom_range(0, 1)), 1'b1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule